// File: doc/BRIEF.md
# SPI Message Engine with Write-Then-Read Prepend

A register-controlled SPI master that runs exactly one chip-select-framed message per start command. Software fills a transmit byte buffer, programs a control word holding the message type and byte count, and then writes a command word. The command word carries a start opcode, the index of the slave to select, the number of leading write bytes and a single-data-line flag. The engine drives the chosen chip select low and clocks the message in SPI mode 0. It then releases chip select, waits a programmable idle gap and sets a done flag in a write-one-to-clear status register. A mask register gates that status onto the interrupt line.

Three message types are supported. Full duplex sends buffered bytes and keeps every received byte. Write-only sends buffered bytes and keeps nothing. Prepend sends up to 15 buffered bytes and then reads the requested number of bytes while a fill byte is driven, all in one chip-select window, so a command-then-data read from a serial flash needs only one message. Received bytes land in a receive buffer from offset 0. Both buffers and all registers are reached through a simple word-wide register bus with one cycle of read latency.

Top module: `spi_msg_engine`

## Requirements
- R1: A command write starts a message only when command bits [3:0] equal 3 and the engine is idle; any other opcode leaves chip selects, SCK and status untouched.
- R2: A start command written while a message is running is ignored: the running message keeps its slave and byte count, and no second message follows.
- R3: Only chip select line `cmd[7:4]` goes low, and it stays low for the whole message. After it rises, done is set after (clk[5:3] + 1) SCK half-periods.
- R4: Type 0 (ctl[9:8] = 0) shifts ctl[7:0] bytes from transmit offsets 0 upward and stores each received byte at the same receive offset.
- R5: Type 1 (ctl[9:8] = 1) shifts ctl[7:0] bytes from the transmit buffer and leaves the receive buffer unchanged.
- R6: Type 2 (ctl[9:8] = 2) first shifts `cmd[11:8]` bytes from transmit offset 0 and discards the bytes received during them. It then shifts ctl[7:0] copies of the fill register and stores the received bytes from receive offset 0.
- R7: clk[7] = 1 sends and receives each byte LSB first; clk[7] = 0 sends and receives MSB first.
- R8: The SCK half-period, in system clocks, is HALF_BASE for code clk[2:0] = 7, HALF_BASE*5/4 for code 0, and HALF_BASE << (7 - code) for codes 1 to 6.
- R9: Status bit 0 (done) is set at the end of a message and cleared by writing 1 to it. `irq_o` is high exactly while some status bit and its mask bit are both set.
- R10: A start is refused, with no chip select activity, when the needed transmit bytes exceed TX_DEPTH (status bit 3), the received bytes exceed RX_DEPTH (bit 1), the count is 0 for types 0, 1 and 3 (bit 2), or the count is 0 for type 2 (bit 4).
- R11: With cmd[12] = 1, `mosi_oe` is low during the read phase of a type 2 message, and every received bit is taken from `mosi_i`.
- R12: After reset all chip selects are high, SCK is low, `irq_o` is low, status reads 0, fill reads 0xFF and the clock register reads 0x10.
- R13: SCK idles low, MOSI changes only while SCK is low, and input bits are sampled on the rising SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | ADDR_W | Bus address: [7:6]=0 registers, 1 transmit buffer, 2 receive buffer |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, valid one cycle after `bus_rd` |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for the data-out line |
| mosi_i | input | 1 | Data-out line read back, used as the data line in single-line mode |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Active-low chip selects |
| irq_o | output | 1 | Masked interrupt |

## Verification
A bus write takes effect at the edge that ends the write cycle. Chip select falls at that edge and the first rising SCK edge comes one half-period after the following edge. Register reads are sampled at the falling clock edge after the read strobe, which is exactly one register stage later. The serial monitor samples MOSI on rising SCK, so it never reads data on the edge where the data changes. The idle gap and SCK period are measured as counts of whole cycles and as time between rising SCK edges, and compared with the exact values that R3 and R8 predict. Received data and status are read only after the interrupt rises, and done is set only after the gap, so each of these checks sees final values.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;

  typedef enum logic [1:0] {
    MT_DUPLEX  = 2'd0,
    MT_WRITE   = 2'd1,
    MT_PREPEND = 2'd2,
    MT_RSVD    = 2'd3
  } msg_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } eng_state_e;

  // status bit positions (decoded by software)
  localparam int SB_DONE  = 0;
  localparam int SB_RXOVF = 1;
  localparam int SB_TXUNF = 2;
  localparam int SB_TXOVF = 3;
  localparam int SB_RXUNF = 4;

  localparam logic [3:0] OP_START = 4'h3;

  typedef struct packed {
    msg_type_e  mtype;
    logic [3:0] prep;
    logic       lsb;
    logic       three;
    logic [3:0] slave;
    logic [2:0] ssoff;
  } msg_cfg_t;

  // SCK half-period in system clocks for a rate code
  function automatic int unsigned half_period(input logic [2:0] code,
                                              input int unsigned base);
    int unsigned r;
    case (code)
      3'd7:    r = base;
      3'd0:    r = (base * 5) / 4;
      default: r = base << (32'd7 - 32'(code));
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_byte_buf.sv
module spi_byte_buf #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];

endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int HALF_BASE = 4,
  localparam int DIV_W = $clog2(HALF_BASE * 64 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d, half_m1;

  assign half_m1 = DIV_W'(spi_msg_pkg::half_period(code, HALF_BASE) - 1);
  assign tick    = run && (cnt_q == half_m1);

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
  import spi_msg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TX_IDX_W = 5,
  parameter int RX_IDX_W = 5,
  parameter int NUM_CS   = 8,
  localparam int TOT_W   = CNT_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    count,
  input  msg_cfg_t            cfg,
  input  logic [7:0]          fill,
  input  logic                tick,
  input  logic [7:0]          tx_byte,
  input  logic                mosi_i,
  input  logic                miso_i,
  output logic                run_div,
  output logic [TX_IDX_W-1:0] tx_idx,
  output logic                rx_we,
  output logic [RX_IDX_W-1:0] rx_idx,
  output logic [7:0]          rx_byte,
  output logic                sck,
  output logic                mosi_o,
  output logic                mosi_oe,
  output logic [NUM_CS-1:0]   cs_n,
  output logic                busy,
  output logic                done
);

  eng_state_e       st_q, st_d;
  msg_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TOT_W-1:0] byte_q, byte_d;
  logic [2:0]       bit_q, bit_d, gap_q, gap_d;
  logic             sck_q, sck_d;
  logic [7:0]       sh_q, sh_d, rsh_q, rsh_d;

  logic [TOT_W-1:0] pre, total;
  logic             in_read, store, samp, cs_act;
  logic [7:0]       rsh_nx;

  assign pre     = (cfg_q.mtype == MT_PREPEND) ? TOT_W'(cfg_q.prep) : '0;
  assign total   = pre + TOT_W'(cnt_q);
  assign in_read = (cfg_q.mtype == MT_PREPEND) && (byte_q >= pre);
  assign store   = (cfg_q.mtype == MT_PREPEND) ? in_read : (cfg_q.mtype != MT_WRITE);
  assign samp    = cfg_q.three ? mosi_i : miso_i;
  assign rsh_nx  = cfg_q.lsb ? {samp, rsh_q[7:1]} : {rsh_q[6:0], samp};

  assign tx_idx  = TX_IDX_W'(byte_q);
  assign rx_idx  = RX_IDX_W'(byte_q - pre);
  assign rx_byte = rsh_q;
  assign sck     = sck_q;
  assign mosi_o  = cfg_q.lsb ? sh_q[0] : sh_q[7];
  assign busy    = (st_q != ST_IDLE);
  assign run_div = (st_q == ST_SHIFT) || (st_q == ST_GAP);
  assign cs_act  = (st_q == ST_LOAD) || (st_q == ST_SHIFT);
  assign mosi_oe = !(busy && cfg_q.three && in_read);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && (cfg_q.slave == 4'(g)));
  end

  always_comb begin
    st_d   = st_q;
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    bit_d  = bit_q;
    gap_d  = gap_q;
    sck_d  = sck_q;
    sh_d   = sh_q;
    rsh_d  = rsh_q;
    rx_we  = 1'b0;
    done   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_LOAD;
        cfg_d  = cfg;
        cnt_d  = count;
        byte_d = '0;
      end
      ST_LOAD: begin
        sh_d  = in_read ? fill : tx_byte;
        bit_d = '0;
        sck_d = 1'b0;
        st_d  = ST_SHIFT;
      end
      ST_SHIFT: if (tick) begin
        if (!sck_q) begin
          sck_d = 1'b1;
          rsh_d = rsh_nx;
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            rx_we = store;
            if (byte_q == total - 1'b1) begin
              st_d  = ST_GAP;
              gap_d = '0;
            end else begin
              st_d   = ST_LOAD;
              byte_d = byte_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = cfg_q.lsb ? {1'b0, sh_q[7:1]} : {sh_q[6:0], 1'b0};
          end
        end
      end
      ST_GAP: if (tick) begin
        if (gap_q == cfg_q.ssoff) begin
          st_d = ST_IDLE;
          done = 1'b1;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      bit_q  <= '0;
      gap_q  <= '0;
      sck_q  <= 1'b0;
      sh_q   <= '0;
      rsh_q  <= '0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      bit_q  <= bit_d;
      gap_q  <= gap_d;
      sck_q  <= sck_d;
      sh_q   <= sh_d;
      rsh_q  <= rsh_d;
    end
  end

endmodule

// File: rtl/spi_msg_engine.sv
module spi_msg_engine
  import spi_msg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int TX_DEPTH  = 32,
  parameter int RX_DEPTH  = 32,
  parameter int CNT_W     = 8,
  parameter int NUM_CS    = 8,
  parameter int HALF_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              irq_o
);

  localparam int TX_IDX_W = $clog2(TX_DEPTH);
  localparam int RX_IDX_W = $clog2(RX_DEPTH);
  localparam int LOW_W    = ADDR_W - 2;
  localparam int CTL_W    = CNT_W + 2;
  localparam logic [LOW_W-1:0] A_CMD = LOW_W'(0), A_CTL = LOW_W'(1), A_CLK = LOW_W'(2),
                               A_FILL = LOW_W'(3), A_MASK = LOW_W'(4), A_STAT = LOW_W'(5);

  logic [15:0]      cmd_q, cmd_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [7:0]       clkr_q, clkr_d, fill_q, fill_d;
  logic [4:0]       mask_q, mask_d, stat_q, stat_d, stat_set, stat_clr;
  logic [15:0]      rdata_q, rdata_d;

  logic [1:0]       region;
  logic [LOW_W-1:0] low;
  logic             reg_wr, wr_cmd, go, launch;
  msg_type_e        mt;
  logic [CNT_W-1:0] cnt, tx_need, rx_need;
  logic             e_txovf, e_rxovf, e_txunf, e_rxunf;
  msg_cfg_t         cfg;

  logic                tick, run_div, busy, core_done, rx_we;
  logic [TX_IDX_W-1:0] tx_idx;
  logic [RX_IDX_W-1:0] rx_idx;
  logic [7:0]          tx_byte, rx_byte, rx_rd;

  assign region = bus_addr[ADDR_W-1 -: 2];
  assign low    = bus_addr[LOW_W-1:0];
  assign reg_wr = bus_wr && (region == 2'd0);
  assign wr_cmd = reg_wr && (low == A_CMD);

  // start validation
  assign mt      = msg_type_e'(ctl_q[CTL_W-1:CNT_W]);
  assign cnt     = ctl_q[CNT_W-1:0];
  assign tx_need = (mt == MT_PREPEND) ? CNT_W'(bus_wdata[11:8]) : cnt;
  assign rx_need = (mt == MT_WRITE) ? '0 : cnt;
  assign e_txovf = 32'(tx_need) > TX_DEPTH;
  assign e_rxovf = 32'(rx_need) > RX_DEPTH;
  assign e_txunf = (mt != MT_PREPEND) && (cnt == '0);
  assign e_rxunf = (mt == MT_PREPEND) && (cnt == '0);
  assign go      = wr_cmd && (bus_wdata[3:0] == OP_START) && !busy;
  assign launch  = go && !(e_txovf || e_rxovf || e_txunf || e_rxunf);

  assign cfg.mtype = mt;
  assign cfg.prep  = bus_wdata[11:8];
  assign cfg.lsb   = clkr_q[7];
  assign cfg.three = bus_wdata[12];
  assign cfg.slave = bus_wdata[7:4];
  assign cfg.ssoff = clkr_q[5:3];

  always_comb begin
    stat_set           = '0;
    stat_set[SB_DONE]  = core_done;
    stat_set[SB_RXOVF] = go && e_rxovf;
    stat_set[SB_TXUNF] = go && e_txunf;
    stat_set[SB_TXOVF] = go && e_txovf;
    stat_set[SB_RXUNF] = go && e_rxunf;
    stat_clr = (reg_wr && (low == A_STAT)) ? bus_wdata[4:0] : '0;
    stat_d   = (stat_q & ~stat_clr) | stat_set;

    cmd_d  = wr_cmd ? bus_wdata : cmd_q;
    ctl_d  = (reg_wr && (low == A_CTL))  ? bus_wdata[CTL_W-1:0] : ctl_q;
    clkr_d = (reg_wr && (low == A_CLK))  ? bus_wdata[7:0] : clkr_q;
    fill_d = (reg_wr && (low == A_FILL)) ? bus_wdata[7:0] : fill_q;
    mask_d = (reg_wr && (low == A_MASK)) ? bus_wdata[4:0] : mask_q;

    rdata_d = rdata_q;
    if (bus_rd) begin
      rdata_d = '0;
      if (region == 2'd0) begin
        case (low)
          A_CMD:   rdata_d = cmd_q;
          A_CTL:   rdata_d = 16'(ctl_q);
          A_CLK:   rdata_d = 16'(clkr_q);
          A_FILL:  rdata_d = 16'(fill_q);
          A_MASK:  rdata_d = 16'(mask_q);
          A_STAT:  rdata_d = 16'(stat_q);
          default: rdata_d = '0;
        endcase
      end else if (region == 2'd2 && 32'(low) < RX_DEPTH) begin
        rdata_d = 16'(rx_rd);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      ctl_q   <= '0;
      clkr_q  <= 8'h10;
      fill_q  <= 8'hFF;
      mask_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      cmd_q   <= cmd_d;
      ctl_q   <= ctl_d;
      clkr_q  <= clkr_d;
      fill_q  <= fill_d;
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = |(stat_q & mask_q);

  spi_byte_buf #(.DEPTH(TX_DEPTH)) tx_buf_i (
    .clk   (clk),
    .we    (bus_wr && (region == 2'd1) && (32'(low) < TX_DEPTH)),
    .widx  (low[TX_IDX_W-1:0]),
    .wdata (bus_wdata[7:0]),
    .ridx  (tx_idx),
    .rdata (tx_byte)
  );

  spi_byte_buf #(.DEPTH(RX_DEPTH)) rx_buf_i (
    .clk   (clk),
    .we    (rx_we),
    .widx  (rx_idx),
    .wdata (rx_byte),
    .ridx  (low[RX_IDX_W-1:0]),
    .rdata (rx_rd)
  );

  spi_clk_div #(.HALF_BASE(HALF_BASE)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_div),
    .code  (clkr_q[2:0]),
    .tick  (tick)
  );

  spi_shift_core #(
    .CNT_W(CNT_W), .TX_IDX_W(TX_IDX_W), .RX_IDX_W(RX_IDX_W), .NUM_CS(NUM_CS)
  ) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (launch),
    .count   (cnt),
    .cfg     (cfg),
    .fill    (fill_q),
    .tick    (tick),
    .tx_byte (tx_byte),
    .mosi_i  (mosi_i),
    .miso_i  (miso_i),
    .run_div (run_div),
    .tx_idx  (tx_idx),
    .rx_we   (rx_we),
    .rx_idx  (rx_idx),
    .rx_byte (rx_byte),
    .sck     (sck_o),
    .mosi_o  (mosi_o),
    .mosi_oe (mosi_oe),
    .cs_n    (cs_n_o),
    .busy    (busy),
    .done    (core_done)
  );

endmodule

// File: rtl/spi_msg_engine_chk.sv
module spi_msg_engine_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sck,
  input logic              mosi,
  input logic              done,
  input logic              busy,
  input logic              stat_done
);

  // R3: never more than one slave selected
  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R3: done only after chip select has been released
  p_done_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (&cs_n));

  // R13: SCK idles low whenever no slave is selected
  p_sck_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  // R13: MOSI is settled before a rising SCK edge
  p_mosi_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  // R9: end of message sets the done flag
  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stat_done);

  // R2: no chip select outside a running message
  p_idle_no_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n));

endmodule

bind spi_msg_engine spi_msg_engine_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n_o),
  .sck       (sck_o),
  .mosi      (mosi_o),
  .done      (core_done),
  .busy      (busy),
  .stat_done (stat_q[0])
);

// File: tb/spi_msg_engine_tb_top.sv
module spi_msg_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi_o, mosi_oe, mosi_i, miso_i, irq;
  logic [7:0]  cs_n;

  always #4 clk = ~clk;

  spi_msg_engine dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(miso_i), .cs_n_o(cs_n), .irq_o(irq)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  bit   lsb_mode = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] slv(input int k);
    return 8'hC3 + 8'(k * 17);
  endfunction

  // ---------------- slave model + monitor ----------------
  logic slv_bit = 1'b0;
  int   sk = 0, sb = 0;
  wire  cs_act = ~&cs_n;
  assign miso_i = slv_bit;
  assign mosi_i = mosi_oe ? mosi_o : slv_bit;

  int         mbit = 0, oe_low = 0, nbytes = 0;
  bit         any_oe = 0;
  logic [7:0] cap = '0, cs_last = '1;
  time        t_r0 = 0, rise_dt = 0;

  function automatic logic bit_of(input logic [7:0] b, input int i);
    return lsb_mode ? b[i] : b[7-i];
  endfunction

  always @(posedge cs_act) begin
    sk = 0; sb = 0; mbit = 0; any_oe = 0; oe_low = 0; nbytes = 0;
    slv_bit = bit_of(slv(0), 0);
  end

  always @(negedge sck) if (cs_act) begin
    sb++;
    if (sb == 8) begin sb = 0; sk++; end
    slv_bit = bit_of(slv(sk), sb);
  end

  // monitor: pops the scoreboard when a driven byte completes
  always @(posedge sck) if (cs_act) begin
    cs_last = cs_n;
    if (mosi_oe) begin
      cap = lsb_mode ? {mosi_o, cap[7:1]} : {cap[6:0], mosi_o};
      any_oe = 1;
    end else oe_low++;
    mbit++;
    if (mbit == 1) t_r0 = $time;
    if (mbit == 2) rise_dt = $time - t_r0;
    if (mbit == 8) begin
      mbit = 0;
      if (any_oe) begin
        nbytes++;
        if (exp_q.size() == 0) chk("R2/R4", "unexpected MOSI byte", int'(cap), -1);
        else chk("R4/R6/R7", "MOSI byte", int'(cap), int'(exp_q.pop_front()));
      end
      any_oe = 0;
    end
  end

  // ---------------- bus driver ----------------
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic load_tx(input int n, input logic [7:0] base, input logic [7:0] step);
    for (int i = 0; i < n; i++) begin
      wr(8'h40 + 8'(i), 16'(base + 8'(i) * step));
      exp_q.push_back(base + 8'(i) * step);
    end
  endtask

  // start a message and measure cycles from chip select release to irq
  task automatic run_msg(input logic [15:0] cmd, output int gap);
    int n;
    wr(8'h00, cmd);
    n = 0;
    while (!cs_act && n < 50) begin @(negedge clk); n++; end
    while (cs_act && n < 60000) begin @(negedge clk); n++; end
    gap = 0;
    while (!irq && gap < 5000) begin @(negedge clk); gap++; end
  endtask

  task automatic clr_stat();
    wr(8'h05, 16'h001F);
  endtask

  logic [15:0] d;
  int          g;

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "cs_n after reset", int'(cs_n), 8'hFF);
    chk("R12", "sck after reset", int'(sck), 0);
    chk("R12", "irq after reset", int'(irq), 0);
    rst_n = 1'b1;
    rd(8'h05, d); chk("R12", "status reset", int'(d), 0);
    rd(8'h03, d); chk("R12", "fill reset", int'(d), 8'hFF);
    rd(8'h02, d); chk("R12", "clock reg reset", int'(d), 8'h10);

    wr(8'h04, 16'h0001);
    wr(8'h02, 16'h0017);          // code 7, gap value 2, MSB first

    // R4: full duplex, 4 bytes, slave 0
    load_tx(4, 8'h11, 8'h11);
    wr(8'h01, 16'h0004);
    run_msg(16'h0003, g);
    chk("R3", "gap cycles ssoff=2", g, 12);
    chk("R3", "slave 0 selected", int'(cs_last), 8'hFE);
    chk("R4", "all bytes shifted", exp_q.size(), 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(i), d); chk("R4", "rx byte", int'(d), int'(slv(i)));
    end
    rd(8'h05, d); chk("R9", "done status", int'(d), 1);
    clr_stat();
    chk("R9", "irq after w1c", int'(irq), 0);

    // R5: write only, 3 bytes, slave 5
    load_tx(3, 8'hA5, 8'h01);
    wr(8'h01, 16'h0103);
    run_msg(16'h0053, g);
    chk("R3", "slave 5 selected", int'(cs_last), 8'hDF);
    chk("R5", "all bytes shifted", exp_q.size(), 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h80 + 8'(i), d); chk("R5", "rx unchanged", int'(d), int'(slv(i)));
    end
    clr_stat();

    // R6: prepend 2 then read 3, slave 2
    wr(8'h40, 16'h009F); exp_q.push_back(8'h9F);
    wr(8'h41, 16'h0001); exp_q.push_back(8'h01);
    repeat (3) exp_q.push_back(8'hFF);
    wr(8'h01, 16'h0203);
    run_msg(16'h0223, g);
    chk("R6", "prepend+fill bytes shifted", exp_q.size(), 0);
    chk("R3", "slave 2 selected", int'(cs_last), 8'hFB);
    for (int i = 0; i < 3; i++) begin
      rd(8'h80 + 8'(i), d); chk("R6", "read data from offset 0", int'(d), int'(slv(i + 2)));
    end
    clr_stat();

    // R7: LSB first
    wr(8'h02, 16'h0097); lsb_mode = 1;
    wr(8'h40, 16'h0001); exp_q.push_back(8'h01);
    wr(8'h41, 16'h0080); exp_q.push_back(8'h80);
    wr(8'h01, 16'h0002);
    run_msg(16'h0003, g);
    chk("R7", "lsb bytes shifted", exp_q.size(), 0);
    for (int i = 0; i < 2; i++) begin
      rd(8'h80 + 8'(i), d); chk("R7", "lsb rx byte", int'(d), int'(slv(i)));
    end
    clr_stat();
    lsb_mode = 0;

    // R8: rates; R3: gap with ssoff 0
    wr(8'h40, 16'h003C);
    wr(8'h01, 16'h0101);
    wr(8'h02, 16'h0016); exp_q.push_back(8'h3C);
    run_msg(16'h0003, g);
    chk("R8", "code6 SCK period ns", int'(rise_dt), 2 * 8 * 8);
    clr_stat();
    wr(8'h02, 16'h0010); exp_q.push_back(8'h3C);
    run_msg(16'h0003, g);
    chk("R8", "code0 SCK period ns", int'(rise_dt), 2 * 5 * 8);
    clr_stat();
    wr(8'h02, 16'h0007); exp_q.push_back(8'h3C);
    run_msg(16'h0003, g);
    chk("R8", "code7 SCK period ns", int'(rise_dt), 2 * 4 * 8);
    chk("R3", "gap cycles ssoff=0", g, 4);
    clr_stat();
    wr(8'h02, 16'h0017);

    // R2: second start while busy is ignored
    load_tx(3, 8'h70, 8'h02);
    wr(8'h01, 16'h0103);
    wr(8'h00, 16'h0013);
    repeat (20) @(negedge clk);
    wr(8'h00, 16'h0063);
    g = 0;
    while (!irq && g < 20000) begin @(negedge clk); g++; end
    repeat (100) @(negedge clk);
    chk("R2", "slave 1 kept", int'(cs_last), 8'hFD);
    chk("R2", "byte count kept", nbytes, 3);
    chk("R2", "no second message", int'(cs_n), 8'hFF);
    rd(8'h05, d); chk("R2", "status only done", int'(d), 1);
    clr_stat();

    // R1: wrong opcode does nothing
    wr(8'h00, 16'h0012);
    repeat (40) begin
      @(negedge clk);
      if (cs_act) chk("R1", "cs with bad opcode", 1, 0);
    end
    rd(8'h05, d); chk("R1", "status after bad opcode", int'(d), 0);

    // R10: refused starts
    wr(8'h01, 16'h0028);                 // type0, 40 bytes
    wr(8'h00, 16'h0003);
    repeat (40) @(negedge clk);
    chk("R10", "no cs on overflow", int'(cs_n), 8'hFF);
    rd(8'h05, d); chk("R10", "tx+rx overflow flags", int'(d), 8'h0A);
    chk("R9", "irq masked off", int'(irq), 0);
    wr(8'h04, 16'h001F);
    chk("R9", "irq with full mask", int'(irq), 1);
    clr_stat();
    wr(8'h01, 16'h0100);                 // type1, 0 bytes
    wr(8'h00, 16'h0003);
    rd(8'h05, d); chk("R10", "tx underflow flag", int'(d), 8'h04);
    clr_stat();
    wr(8'h01, 16'h0200);                 // type2, 0 bytes
    wr(8'h00, 16'h0103);
    rd(8'h05, d); chk("R10", "rx underflow flag", int'(d), 8'h10);
    clr_stat();
    wr(8'h04, 16'h0001);

    // R11: single data line, prepend 1 then read 2
    wr(8'h40, 16'h003B); exp_q.push_back(8'h3B);
    wr(8'h01, 16'h0202);
    run_msg(16'h1103, g);
    chk("R11", "prepend byte shifted", exp_q.size(), 0);
    chk("R11", "oe low bits in read", oe_low, 16);
    for (int i = 0; i < 2; i++) begin
      rd(8'h80 + 8'(i), d); chk("R11", "rx from shared line", int'(d), int'(slv(i + 1)));
    end
    clr_stat();

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule